// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block produces the periodic interrupt of a real-time-clock style device. Software writes one control byte that carries a 4-bit rate code and a 3-bit timebase selector. A separate level input enables the periodic source. A free-running strobe `tick_i` drives a signed countdown. Each strobe takes `STEP` counter units off the count. One unit is one period of `BASE_HZ`. When the count reaches zero or goes below it, the block sets a sticky periodic flag, emits a one-cycle pulse toward the flag register, and raises the interrupt request. The period is then added back to the count, so any overshoot carries into the next interval and the long-run rate stays exact.

The length of one period, in counter units, comes from a table built at elaboration. The table holds `BASE_HZ` divided by the selected frequency, for each rate code and each timebase class. The two fastest codes mean different frequencies under the slow timebase than under the fast ones. The countdown reloads with a full period whenever the control byte is written or the enable level changes. An acknowledge input clears the flag and the request. It stands for the read-to-clear of a status register held elsewhere.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `pf_o`, `pf_pulse_o` and `irq_o` are 0, `ctl_o` is 0, and the timebase class is slow.
- R2: A write (`ctl_we_i`) stores `ctl_wdata_i[6:0]` into `ctl_o`. Bits [3:0] are the rate code and bits [6:4] the timebase selector. Bit 7 is dropped.
- R3: Rate code 0 never produces a pulse, a flag or an interrupt.
- R4: Codes 3 to 15 select 8192 Hz down to 2 Hz, halving at each step. The period is `BASE_HZ`/rate units. With the enable high and a strobe every cycle, the first pulse after a reload comes on strobe ceil(period/`STEP`).
- R5: Selector 3'b010 chooses the slow (32 kHz) class. Selectors 3'b001 (1 MHz) and 3'b000 (4 MHz) choose the fast class. Any other selector value keeps the previous class. Codes 1 and 2 mean 256 Hz and 128 Hz in the slow class, and 32768 Hz and 16384 Hz in the fast class.
- R6: On a strobe with the enable high and a nonzero code, the count loses `STEP`. If the result is at or below 0, the block fires and the period is added to that result.
- R7: A control write reloads the count with the full period of the newly written code and selector. A strobe in the same cycle is ignored.
- R8: Any change of `pie_i` between consecutive clock edges reloads the count with the full period.
- R9: Driving `pie_i` low takes `irq_o` to 0 in the same cycle, without waiting for a clock edge. `pf_o` is left unchanged.
- R10: `ack_i` clears `pf_o` and the interrupt request. If a firing happens in the same cycle, the firing takes precedence.
- R11: `pf_pulse_o` is high for exactly the cycle after each firing edge, and `pf_o` is high whenever `pf_pulse_o` is.
- R12: While `pie_i` is low, no firing happens and strobes do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Countdown strobe, one cycle per unit of time |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte: rate code [3:0], timebase selector [6:4] |
| pie_i | input | 1 | Periodic interrupt enable level |
| ack_i | input | 1 | Clears flag and interrupt request |
| ctl_o | output | 7 | Stored control fields |
| pf_o | output | 1 | Sticky periodic flag |
| pf_pulse_o | output | 1 | One-cycle pulse per firing, toward the flag register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures the first-pulse distance for every code in both timebase classes, so a swapped or shifted table entry shows up as a wrong strobe count. It writes an undefined selector after a fast one, to catch a design that falls back to a default class. It runs the fastest code, whose period does not divide evenly by `STEP`. A design that drops the overshoot instead of carrying it fires at the wrong strobes against the cycle model. Further directed steps cover these cases:
- A write in the middle of a count, and a toggle of the enable, to expose designs that skip the reload.
- Dropping the enable with a request pending, which must take `irq_o` low before any clock edge.
- An acknowledge that coincides with a firing, where the firing must win.

// File: rtl/rtc_pi_pkg.sv
// Package: shared encodings and the rate arithmetic of the periodic
// interrupt generator. Assumes frequencies fit in 32 bits.
package rtc_pi_pkg;

    localparam logic [2:0] SEL_32K = 3'b010;
    localparam logic [2:0] SEL_1M  = 3'b001;
    localparam logic [2:0] SEL_4M  = 3'b000;

    // Frequency in Hz for a rate code in a timebase class (0 = off).
    function automatic int unsigned rate_hz(input logic [3:0] code, input logic slow);
        int unsigned r;
        if (code == 4'd0)       r = 0;
        else if (code == 4'd1)  r = slow ? 256 : 32768;
        else if (code == 4'd2)  r = slow ? 128 : 16384;
        else                    r = 32'd8192 >> (code - 4'd3);
        return r;
    endfunction

    // Period in counter units; zero when the code is off.
    function automatic int unsigned period_units(input int unsigned base,
                                                 input logic [3:0] code,
                                                 input logic slow);
        int unsigned r;
        r = rate_hz(code, slow);
        return (r == 0) ? 0 : base / r;
    endfunction

endpackage

// File: rtl/rtc_pi_rate_dec.sv
// Rate decoder: maps a rate code and timebase class to a period in
// counter units through two tables built at elaboration.
// Assumes BASE_HZ / 2 fits in CW-1 bits.
module rtc_pi_rate_dec #(
    parameter int unsigned BASE_HZ = 131072,
    parameter int unsigned CW      = 19
) (
    input  logic [3:0]    code_i,
    input  logic          slow_i,
    output logic [CW-1:0] period_o
);
    import rtc_pi_pkg::*;

    logic [CW-1:0] tab_slow [16];
    logic [CW-1:0] tab_fast [16];

    for (genvar gi = 0; gi < 16; gi++) begin : g_tab
        localparam int unsigned PS = period_units(BASE_HZ, 4'(gi), 1'b1);
        localparam int unsigned PF = period_units(BASE_HZ, 4'(gi), 1'b0);
        assign tab_slow[gi] = CW'(PS);
        assign tab_fast[gi] = CW'(PF);
    end

    // Select the entry for the active class.
    always_comb begin
        period_o = slow_i ? tab_slow[code_i] : tab_fast[code_i];
    end
endmodule

// File: rtl/rtc_pi_count.sv
// Countdown: loads a full period on reload. Otherwise it loses STEP units
// per strobe while running, and fires at or below zero, carrying the
// overshoot by adding the period back. Assumes STEP <= smallest period.
module rtc_pi_count #(
    parameter int unsigned CW   = 19,
    parameter int unsigned STEP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [CW-1:0] period_i,
    output logic          fire_o
);
    localparam logic signed [CW-1:0] STEP_S = CW'(STEP);

    logic signed [CW-1:0] cnt_q;
    logic signed [CW-1:0] dec;

    // Next count after one strobe and the firing decision.
    always_comb begin
        dec    = cnt_q - STEP_S;
        fire_o = !reload_i && run_i && tick_i && (dec <= 0);
    end

    // Count register: reload, carry on expiry, or plain decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (reload_i)          cnt_q <= $signed(period_i);
        else if (run_i && tick_i)   cnt_q <= (dec <= 0) ? dec + $signed(period_i) : dec;
    end
endmodule

// File: rtl/rtc_pi_flags.sv
// Flag stage: sticky periodic flag, one-cycle pulse and interrupt request.
// A firing beats an acknowledge; a low enable masks and drops the request.
module rtc_pi_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic ack_i,
    input  logic pie_i,
    output logic pf_o,
    output logic pulse_o,
    output logic irq_o
);
    logic pf_q, pulse_q, irq_q;

    // Sticky flag with firing priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       pf_q <= 1'b0;
        else if (fire_i)  pf_q <= 1'b1;
        else if (ack_i)   pf_q <= 1'b0;
    end

    // One-cycle pulse after each firing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= fire_i;
    end

    // Request register, dropped by acknowledge or by a low enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                irq_q <= 1'b0;
        else if (fire_i)           irq_q <= 1'b1;
        else if (ack_i || !pie_i)  irq_q <= 1'b0;
    end

    assign pf_o    = pf_q;
    assign pulse_o = pulse_q;
    assign irq_o   = irq_q & pie_i;
endmodule

// File: rtl/rtc_periodic_irq.sv
// Top: holds the control fields and timebase class, detects enable edges,
// and joins decoder, countdown and flag stage.
// Assumes tick_i is a one-cycle strobe at BASE_HZ / STEP.
module rtc_periodic_irq #(
    parameter int unsigned BASE_HZ = 131072,
    parameter int unsigned STEP    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       ctl_we_i,
    input  logic [7:0] ctl_wdata_i,
    input  logic       pie_i,
    input  logic       ack_i,
    output logic [6:0] ctl_o,
    output logic       pf_o,
    output logic       pf_pulse_o,
    output logic       irq_o
);
    import rtc_pi_pkg::*;

    localparam int unsigned CW = $clog2(BASE_HZ / 2 + 1) + 2;

    logic [6:0]    ctl_q;
    logic          slow_q;
    logic          pie_q;
    logic [3:0]    code_nx;
    logic [2:0]    sel_nx;
    logic          slow_nx;
    logic [CW-1:0] period;
    logic          reload;
    logic          fire;

    // Fields as they will stand after this edge, so a write reloads with its own period.
    always_comb begin
        code_nx = ctl_we_i ? ctl_wdata_i[3:0] : ctl_q[3:0];
        sel_nx  = ctl_we_i ? ctl_wdata_i[6:4] : ctl_q[6:4];
        if (sel_nx == SEL_32K)                         slow_nx = 1'b1;
        else if (sel_nx == SEL_1M || sel_nx == SEL_4M) slow_nx = 1'b0;
        else                                           slow_nx = slow_q;
        reload = ctl_we_i || (pie_i != pie_q);
    end

    // Control fields, timebase class and last enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            slow_q <= 1'b1;
            pie_q  <= 1'b0;
        end else begin
            ctl_q  <= {sel_nx, code_nx};
            slow_q <= slow_nx;
            pie_q  <= pie_i;
        end
    end

    rtc_pi_rate_dec #(.BASE_HZ(BASE_HZ), .CW(CW)) u_dec (
        .code_i   (code_nx),
        .slow_i   (slow_nx),
        .period_o (period)
    );

    rtc_pi_count #(.CW(CW), .STEP(STEP)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (reload),
        .run_i    (pie_i && (period != '0)),
        .tick_i   (tick_i),
        .period_i (period),
        .fire_o   (fire)
    );

    rtc_pi_flags u_flg (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .ack_i   (ack_i),
        .pie_i   (pie_i),
        .pf_o    (pf_o),
        .pulse_o (pf_pulse_o),
        .irq_o   (irq_o)
    );

    assign ctl_o = ctl_q;
endmodule

// File: rtl/rtc_periodic_irq_chk.sv
// Checker: port-level properties of the periodic interrupt generator.
module rtc_periodic_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we_i,
    input logic [7:0] ctl_wdata_i,
    input logic       pie_i,
    input logic       ack_i,
    input logic [6:0] ctl_o,
    input logic       pf_o,
    input logic       pf_pulse_o,
    input logic       irq_o
);
    a_r9_irq_needs_pie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pie_i);

    a_r11_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pf_pulse_o |-> pf_o);

    a_r3_code0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[3:0] == 4'd0 && !ctl_we_i) |=> !pf_pulse_o);

    a_r2_ctl_store: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_i |=> ctl_o == $past(ctl_wdata_i[6:0]));

    a_r7_write_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_i |=> !pf_pulse_o);

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (!pf_o || pf_pulse_o));

    a_r12_off_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !pie_i |=> !pf_pulse_o);
endmodule

bind rtc_periodic_irq rtc_periodic_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .pie_i       (pie_i),
    .ack_i       (ack_i),
    .ctl_o       (ctl_o),
    .pf_o        (pf_o),
    .pf_pulse_o  (pf_pulse_o),
    .irq_o       (irq_o)
);

// File: tb/rtc_periodic_irq_tb.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a cycle model written from the requirements.
module rtc_periodic_irq_tb;
    localparam int unsigned BASE = 131072;
    localparam int unsigned STP  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       ctl_we_i = 1'b0;
    logic [7:0] ctl_wdata_i = 8'h00;
    logic       pie_i = 1'b0;
    logic       ack_i = 1'b0;
    logic [6:0] ctl_o;
    logic       pf_o, pf_pulse_o, irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    rtc_periodic_irq #(.BASE_HZ(BASE), .STEP(STP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ctl_we_i(ctl_we_i),
        .ctl_wdata_i(ctl_wdata_i), .pie_i(pie_i), .ack_i(ack_i),
        .ctl_o(ctl_o), .pf_o(pf_o), .pf_pulse_o(pf_pulse_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    // Expected frequency from R4/R5.
    function automatic int bhz(input int code, input bit slow);
        if (code == 0) return 0;
        if (code == 1) return slow ? 256 : 32768;
        if (code == 2) return slow ? 128 : 16384;
        return 8192 >> (code - 3);
    endfunction

    function automatic int bper(input int code, input bit slow);
        return (code == 0) ? 0 : int'(BASE) / bhz(code, slow);
    endfunction

    // Cycle model.
    int m_cnt; bit m_pf, m_irq, m_pulse, m_slow, m_pieq; bit [6:0] m_ctl;
    always @(posedge clk) begin
        int code, per, n; bit sl, fire, rl; bit [2:0] sel;
        if (!rst_n) begin
            m_cnt = 0; m_pf = 0; m_irq = 0; m_pulse = 0; m_slow = 1; m_pieq = 0; m_ctl = 0;
        end else begin
            code = ctl_we_i ? int'(ctl_wdata_i[3:0]) : int'(m_ctl[3:0]);
            sel  = ctl_we_i ? ctl_wdata_i[6:4] : m_ctl[6:4];
            sl   = (sel == 3'b010) ? 1'b1 : (sel <= 3'b001) ? 1'b0 : m_slow;
            per  = bper(code, sl);
            rl   = ctl_we_i || (pie_i != m_pieq);
            fire = 0;
            if (rl) m_cnt = per;
            else if (pie_i && per != 0 && tick_i) begin
                n = m_cnt - int'(STP);
                if (n <= 0) begin fire = 1; m_cnt = n + per; end
                else m_cnt = n;
            end
            m_pulse = fire;
            if (fire) m_pf = 1; else if (ack_i) m_pf = 0;
            if (fire) m_irq = 1; else if (ack_i || !pie_i) m_irq = 0;
            m_pieq = pie_i;
            m_ctl = {sel, code[3:0]};
            m_slow = sl;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: sample 2 ns after the edge and compare with the model (R6).
    task automatic cyc();
        @(posedge clk); #2;
        cycles++;
        if (rst_n) begin
            chk(pf_pulse_o == m_pulse, "R6 pulse", pf_pulse_o, m_pulse);
            chk(pf_o == m_pf, "R6 flag", pf_o, m_pf);
            chk(irq_o == (m_irq & pie_i), "R6 irq", irq_o, m_irq & pie_i);
            chk(ctl_o == m_ctl, "R2 ctl", ctl_o, m_ctl);
        end
    endtask

    task automatic wr(input bit [7:0] d);
        ctl_we_i = 1; ctl_wdata_i = d; tick_i = 0; cyc(); ctl_we_i = 0;
    endtask

    // Strobes every cycle; returns strobes until the first pulse.
    task automatic measure(output int n, input int lim);
        n = 0; tick_i = 1;
        do begin cyc(); n++; end while (!pf_pulse_o && n < lim);
        tick_i = 0;
    endtask

    // Watchdog.
    initial begin
        #(20ns * 195000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, e;
        void'($urandom(32'd1234));
        repeat (2) cyc();
        rst_n = 1; #0;
        // R1: reset state
        chk(pf_o == 0 && irq_o == 0 && pf_pulse_o == 0, "R1 outputs", {pf_o, irq_o, pf_pulse_o}, 0);
        chk(ctl_o == 0, "R1 ctl", ctl_o, 0);
        cyc();
        // R2: bit 7 dropped
        wr(8'hF0);
        chk(ctl_o == 7'h70, "R2 msb dropped", ctl_o, 7'h70);
        // R3: code 0 silent
        wr(8'h20); pie_i = 1; tick_i = 1;
        repeat (300) cyc();
        chk(pf_o == 0, "R3 code0 no flag", pf_o, 0);
        // R1/R5: reset class is slow; selector 3'b011 keeps it
        wr(8'h31); measure(n, 1000); e = (bper(1, 1) + 2) / 3;
        chk(n == e, "R1 R5 reset slow class", n, e);
        // R4 and R5: every code, both classes
        for (int s = 0; s < 2; s++) begin
            for (int c = 1; c < 16; c++) begin
                wr({1'b0, (s == 1) ? 3'b010 : 3'b000, 4'(c)});
                measure(n, 30000);
                e = (bper(c, s == 1) + int'(STP) - 1) / int'(STP);
                chk(n == e, (c < 3) ? "R5 class rate" : "R4 rate", n, e);
            end
        end
        // R5: undefined selector after 1 MHz keeps fast class
        wr(8'h11); wr(8'h71); measure(n, 1000);
        chk(n == 2, "R5 undefined selector keeps class", n, 2);
        // R6/R11: fast code 1 overshoot carry pattern, pulse per firing
        tick_i = 1; n = 0;
        for (int i = 0; i < 12; i++) begin cyc(); n += pf_pulse_o; end
        chk(n == 9, "R6 carry count over 12 strobes", n, 9);
        // R7: write mid count reloads
        wr(8'h06); tick_i = 1; repeat (10) cyc();
        wr(8'h06); measure(n, 1000); e = (bper(6, 0) + 2) / 3;
        chk(n == e, "R7 reload on write", n, e);
        // R8: enable toggle reloads
        tick_i = 1; repeat (15) cyc();
        pie_i = 0; tick_i = 0; cyc(); pie_i = 1; cyc();
        measure(n, 1000);
        chk(n == e, "R8 reload on enable change", n, e);
        // R9: enable low drops irq at once, flag kept
        chk(irq_o == 1, "R9 irq pending", irq_o, 1);
        pie_i = 0; #1;
        chk(irq_o == 0, "R9 irq drops same cycle", irq_o, 0);
        chk(pf_o == 1, "R9 flag kept", pf_o, 1);
        // R12: no counting while off
        tick_i = 1; ack_i = 1; cyc(); ack_i = 0;
        repeat (200) cyc();
        chk(pf_o == 0, "R12 no fire while off", pf_o, 0);
        // R10: ack coinciding with a firing; firing wins
        wr(8'h01); pie_i = 1; tick_i = 0; cyc();
        tick_i = 1; cyc(); ack_i = 1; cyc(); ack_i = 0;
        chk(pf_o == 1 && pf_pulse_o == 1, "R10 fire beats ack", pf_o, 1);
        tick_i = 0; ack_i = 1; cyc(); ack_i = 0;
        chk(pf_o == 0 && irq_o == 0, "R10 ack clears", {pf_o, irq_o}, 0);
        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            tick_i = $urandom_range(0, 1);
            ack_i = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 63) == 0) pie_i = ~pie_i;
            ctl_we_i = ($urandom_range(0, 99) == 0);
            ctl_wdata_i = {1'($urandom), 3'($urandom), 4'($urandom_range(0, 6))};
            cyc();
        end
        ctl_we_i = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule